// File: doc/BRIEF.md
# Memory Read-Protection Access Gate

This block decides, command by command, whether the debug port and the in-system programming path may touch on-chip memory. A boot-time enable input sets the protection state once, in the first clock after reset is released. While protection is on, the debug port is held closed and every programming command that reads, writes or runs code in RAM or flash is refused. Commands that touch no memory still pass.

A flash erase command is always accepted, whatever the protection state. The block hands the sector range to the flash through a request/acknowledge pair and keeps track of that erase until the flash reports that it is done or aborted. Protection is lifted only when an erase covering every user sector completes without abort. Once lifted, it stays off until the next reset.

Commands arrive as a valid/ready handshake carrying a kind, a target region and a sector range. Each accepted command gets a one-cycle response in the next cycle, with a grant flag and a status code.

Top module: `rdprot_gate`

## Requirements
- R1: During reset `prot_active` is 1 and `cmd_ready`, `dbg_enable`, `dbg_gnt`, `resp_valid` and `erase_req` are 0. `cmd_ready` stays 0 in the first cycle after reset release. At the first rising edge with reset released, `prot_active` takes `boot_prot_en` and `cmd_ready` goes to 1. A command offered earlier waits.
- R2: After loading, `dbg_enable` is the inverse of `prot_active`. `dbg_gnt` is 1 in the cycle after an edge where `dbg_req` and `dbg_enable` were both 1, and 0 otherwise.
- R3: An accepted command (`cmd_valid` and `cmd_ready` at an edge) gives `resp_valid`=1 for exactly the following cycle. While protected, a command whose kind is neither identify (0) nor erase (3), and whose region is RAM (1), flash (2) or reserved (3), is refused with `resp_grant`=0 and `resp_status`=2 (deny).
- R4: While protected, an identify command (kind 0) or any command with region none (0) is granted: `resp_grant`=1, `resp_status`=1.
- R5: An erase (kind 3) with `cmd_sect_lo` <= `cmd_sect_hi` < NUM_SECT is granted in either protection state. `erase_req` rises in the response cycle, with `erase_full`=1 exactly when the range runs from sector 0 to sector NUM_SECT-1.
- R6: An erase whose range has lo > hi (or hi >= NUM_SECT) is answered with `resp_grant`=0 and `resp_status`=3 (bad argument), and no erase starts.
- R7: While unprotected, every non-erase command is granted with status 1, whatever its region or range.
- R8: When `fl_done`=1 and `fl_abort`=0 at an edge while a full erase is outstanding, `prot_active` is 0 from the cycle after that edge, and `dbg_enable` is 1.
- R9: When a partial erase completes, or any erase ends with `fl_abort`=1 (including together with `fl_done`), `prot_active` stays unchanged.
- R10: While `erase_req` is 1, including the cycle in which `fl_done` arrives, `cmd_ready` is 0, so no command is answered in the cycle after that acknowledge.
- R11: Once `prot_active` has fallen after loading, it stays 0 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| boot_prot_en | input | 1 | Protection setting, sampled once after reset |
| dbg_req | input | 1 | Debug-port access request |
| dbg_enable | output | 1 | Debug port open (gate) |
| dbg_gnt | output | 1 | Registered debug grant |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted at this edge if valid |
| cmd_kind | input | 3 | Command kind (0 identify, 1 read, 2 write, 3 erase, 4..7 other memory ops) |
| cmd_region | input | 2 | Target region (0 none, 1 RAM, 2 flash, 3 reserved) |
| cmd_sect_lo | input | SECT_W | First sector of an erase |
| cmd_sect_hi | input | SECT_W | Last sector of an erase |
| resp_valid | output | 1 | Response present (one cycle) |
| resp_grant | output | 1 | Command allowed |
| resp_status | output | 2 | 0 idle, 1 ok, 2 deny, 3 bad argument |
| erase_req | output | 1 | Erase outstanding at the flash |
| erase_full | output | 1 | Outstanding erase covers all sectors |
| erase_lo | output | SECT_W | Erase range start to flash |
| erase_hi | output | SECT_W | Erase range end to flash |
| fl_done | input | 1 | Flash reports erase finished |
| fl_abort | input | 1 | Flash reports erase abandoned |
| prot_active | output | 1 | Protection state |

## Verification
The protection state appears one edge after reset release. A command's response appears in the cycle after the edge that accepts it, and `erase_req` rises in that same cycle. Protection clears one edge after a clean full-erase acknowledge, and `dbg_gnt` follows `dbg_req` by one edge. The bench drives every input at the falling edge. It reads results one time unit after the rising edge at which they are due, and reads the stall conditions just before that edge. It then also checks that each response has gone one cycle later.

// File: rtl/rdprot_pkg.sv
package rdprot_pkg;

  typedef enum logic [2:0] {
    K_IDENT = 3'd0,
    K_READ  = 3'd1,
    K_WRITE = 3'd2,
    K_ERASE = 3'd3,
    K_EXEC  = 3'd4,
    K_BLANK = 3'd5,
    K_CMP   = 3'd6,
    K_OTHER = 3'd7
  } kind_e;

  typedef enum logic [1:0] {
    RG_NONE  = 2'd0,
    RG_RAM   = 2'd1,
    RG_FLASH = 2'd2,
    RG_RSVD  = 2'd3
  } region_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_OK     = 2'd1,
    ST_DENY   = 2'd2,
    ST_BADARG = 2'd3
  } status_e;

  // sector range is well formed for an array of n sectors
  function automatic logic range_ok(int unsigned lo, int unsigned hi, int unsigned n);
    return (lo <= hi) && (hi < n);
  endfunction

  // range spans the whole user area
  function automatic logic range_full(int unsigned lo, int unsigned hi, int unsigned n);
    return (lo == 0) && (hi == n - 1);
  endfunction

  // verdict on one command
  function automatic status_e decide(logic prot, kind_e k, region_e r,
                                     int unsigned lo, int unsigned hi, int unsigned n);
    if (k == K_ERASE) return range_ok(lo, hi, n) ? ST_OK : ST_BADARG;
    if (!prot) return ST_OK;
    if (k == K_IDENT || r == RG_NONE) return ST_OK;
    return ST_DENY;
  endfunction

endpackage

// File: rtl/rdprot_boot_ctl.sv
module rdprot_boot_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic boot_prot_en,
  input  logic clear_evt,
  output logic loaded,
  output logic prot
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded <= 1'b0;
      prot   <= 1'b1;
    end else if (!loaded) begin
      loaded <= 1'b1;
      prot   <= boot_prot_en;
    end else if (clear_evt) begin
      prot   <= 1'b0;
    end
  end

endmodule

// File: rtl/rdprot_erase_trk.sv
module rdprot_erase_trk #(
  parameter int NUM_SECT = 16,
  parameter int SECT_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SECT_W-1:0] lo,
  input  logic [SECT_W-1:0] hi,
  input  logic              fl_done,
  input  logic              fl_abort,
  output logic              busy,
  output logic              full,
  output logic [SECT_W-1:0] lo_q,
  output logic [SECT_W-1:0] hi_q,
  output logic              finish_evt,
  output logic              clear_evt
);
  import rdprot_pkg::*;

  assign finish_evt = busy & (fl_done | fl_abort);
  assign clear_evt  = busy & full & fl_done & ~fl_abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      full <= 1'b0;
      lo_q <= '0;
      hi_q <= '0;
    end else if (start) begin
      busy <= 1'b1;
      full <= range_full(int'(lo), int'(hi), NUM_SECT);
      lo_q <= lo;
      hi_q <= hi;
    end else if (finish_evt) begin
      busy <= 1'b0;
      full <= 1'b0;
    end
  end

endmodule

// File: rtl/rdprot_resp.sv
module rdprot_resp (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fire,
  input  rdprot_pkg::status_e verdict,
  output logic                resp_valid,
  output logic                resp_grant,
  output logic [1:0]          resp_status
);
  import rdprot_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid  <= 1'b0;
      resp_grant  <= 1'b0;
      resp_status <= ST_IDLE;
    end else begin
      resp_valid  <= fire;
      resp_grant  <= fire && (verdict == ST_OK);
      resp_status <= fire ? verdict : ST_IDLE;
    end
  end

endmodule

// File: rtl/rdprot_dbg_gate.sv
module rdprot_dbg_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic loaded,
  input  logic prot,
  input  logic dbg_req,
  output logic dbg_enable,
  output logic dbg_gnt
);

  assign dbg_enable = loaded & ~prot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dbg_gnt <= 1'b0;
    else        dbg_gnt <= dbg_req & dbg_enable;
  end

endmodule

// File: rtl/rdprot_gate.sv
module rdprot_gate #(
  parameter int  NUM_SECT = 16,
  localparam int SECT_W   = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_prot_en,
  input  logic              dbg_req,
  output logic              dbg_enable,
  output logic              dbg_gnt,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_kind,
  input  logic [1:0]        cmd_region,
  input  logic [SECT_W-1:0] cmd_sect_lo,
  input  logic [SECT_W-1:0] cmd_sect_hi,
  output logic              resp_valid,
  output logic              resp_grant,
  output logic [1:0]        resp_status,
  output logic              erase_req,
  output logic              erase_full,
  output logic [SECT_W-1:0] erase_lo,
  output logic [SECT_W-1:0] erase_hi,
  input  logic              fl_done,
  input  logic              fl_abort,
  output logic              prot_active
);
  import rdprot_pkg::*;

  // named internal events
  logic    loaded;
  logic    prot;
  logic    busy;
  logic    cmd_fire;
  logic    erase_start;
  logic    erase_finish;
  logic    prot_clear_evt;
  status_e verdict;

  assign cmd_ready   = loaded & ~busy;
  assign cmd_fire    = cmd_valid & cmd_ready;
  assign verdict     = decide(prot, kind_e'(cmd_kind), region_e'(cmd_region),
                              int'(cmd_sect_lo), int'(cmd_sect_hi), NUM_SECT);
  assign erase_start = cmd_fire && (kind_e'(cmd_kind) == K_ERASE) && (verdict == ST_OK);
  assign erase_req   = busy;
  assign prot_active = prot;

  rdprot_boot_ctl u_boot (
    .clk          (clk),
    .rst_n        (rst_n),
    .boot_prot_en (boot_prot_en),
    .clear_evt    (prot_clear_evt),
    .loaded       (loaded),
    .prot         (prot)
  );

  rdprot_erase_trk #(.NUM_SECT(NUM_SECT), .SECT_W(SECT_W)) u_erase (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (erase_start),
    .lo         (cmd_sect_lo),
    .hi         (cmd_sect_hi),
    .fl_done    (fl_done),
    .fl_abort   (fl_abort),
    .busy       (busy),
    .full       (erase_full),
    .lo_q       (erase_lo),
    .hi_q       (erase_hi),
    .finish_evt (erase_finish),
    .clear_evt  (prot_clear_evt)
  );

  rdprot_resp u_resp (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire        (cmd_fire),
    .verdict     (verdict),
    .resp_valid  (resp_valid),
    .resp_grant  (resp_grant),
    .resp_status (resp_status)
  );

  rdprot_dbg_gate u_dbg (
    .clk        (clk),
    .rst_n      (rst_n),
    .loaded     (loaded),
    .prot       (prot),
    .dbg_req    (dbg_req),
    .dbg_enable (dbg_enable),
    .dbg_gnt    (dbg_gnt)
  );

endmodule

// File: rtl/rdprot_gate_chk.sv
module rdprot_gate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       loaded,
  input logic       prot_active,
  input logic       dbg_req,
  input logic       dbg_enable,
  input logic       dbg_gnt,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic       resp_valid,
  input logic       resp_grant,
  input logic [1:0] resp_status,
  input logic       erase_req,
  input logic       erase_full,
  input logic       fl_done,
  input logic       fl_abort
);

  p_stall_before_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !loaded |-> !cmd_ready);

  p_dbg_closed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    prot_active |-> !dbg_enable);

  p_dbg_gnt_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_gnt |-> $past(dbg_req && dbg_enable));

  p_resp_after_fire_r3: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(cmd_valid && cmd_ready));

  p_deny_only_prot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_status == 2'd2) |-> (prot_active && !resp_grant));

  p_erase_granted_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(erase_req) |-> (resp_valid && resp_grant));

  p_badarg_no_erase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_status == 2'd3) |-> (!resp_grant && !$rose(erase_req)));

  p_open_grants_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && $past(loaded && !prot_active) && resp_status != 2'd3) |-> resp_grant);

  p_clear_on_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(prot_active) && $past(loaded)) |->
      $past(erase_req && erase_full && fl_done && !fl_abort));

  p_abort_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_req && fl_abort && prot_active) |=> prot_active);

  p_busy_stalls_r10: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> !cmd_ready);

  p_stays_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(loaded) && !$past(prot_active)) |-> !prot_active);

endmodule

bind rdprot_gate rdprot_gate_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .loaded      (loaded),
  .prot_active (prot_active),
  .dbg_req     (dbg_req),
  .dbg_enable  (dbg_enable),
  .dbg_gnt     (dbg_gnt),
  .cmd_valid   (cmd_valid),
  .cmd_ready   (cmd_ready),
  .resp_valid  (resp_valid),
  .resp_grant  (resp_grant),
  .resp_status (resp_status),
  .erase_req   (erase_req),
  .erase_full  (erase_full),
  .fl_done     (fl_done),
  .fl_abort    (fl_abort)
);

// File: tb/test_rdprot_gate.sv
module test_rdprot_gate;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       boot_prot_en = 1'b1;
  logic       dbg_req = 1'b0;
  logic       dbg_enable, dbg_gnt;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [2:0] cmd_kind = 3'd0;
  logic [1:0] cmd_region = 2'd0;
  logic [3:0] cmd_sect_lo = 4'd0;
  logic [3:0] cmd_sect_hi = 4'd0;
  logic       resp_valid, resp_grant;
  logic [1:0] resp_status;
  logic       erase_req, erase_full;
  logic [3:0] erase_lo, erase_hi;
  logic       fl_done = 1'b0;
  logic       fl_abort = 1'b0;
  logic       prot_active;

  int n_chk = 0;
  int n_bad = 0;
  bit exp_prot = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  rdprot_gate #(.NUM_SECT(NS)) i_rdprot_gate (
    .clk(clk), .rst_n(rst_n), .boot_prot_en(boot_prot_en),
    .dbg_req(dbg_req), .dbg_enable(dbg_enable), .dbg_gnt(dbg_gnt),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
    .cmd_region(cmd_region), .cmd_sect_lo(cmd_sect_lo), .cmd_sect_hi(cmd_sect_hi),
    .resp_valid(resp_valid), .resp_grant(resp_grant), .resp_status(resp_status),
    .erase_req(erase_req), .erase_full(erase_full), .erase_lo(erase_lo),
    .erase_hi(erase_hi), .fl_done(fl_done), .fl_abort(fl_abort),
    .prot_active(prot_active)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // expected status worked out from the rules
  function automatic int want(bit p, int k, int r, int lo, int hi);
    if (k == 3) begin
      if (hi < lo || hi >= NS) return 3;
      return 1;
    end
    if (p == 1'b0) return 1;
    if (k == 0) return 1;
    if (r == 0) return 1;
    return 2;
  endfunction

  task automatic issue(input int k, input int r, input int lo, input int hi, input string tag);
    int st;
    st = want(exp_prot, k, r, lo, hi);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_kind = 3'(k); cmd_region = 2'(r);
    cmd_sect_lo = 4'(lo); cmd_sect_hi = 4'(hi);
    while (!cmd_ready) @(negedge clk);
    @(posedge clk); #1;
    check({tag, " resp_valid"}, int'(resp_valid), 1);
    check({tag, " resp_status"}, int'(resp_status), st);
    check({tag, " resp_grant"}, int'(resp_grant), (st == 1) ? 1 : 0);
    @(negedge clk); cmd_valid = 1'b0;
    @(posedge clk); #1;
    check("R3 resp lasts one cycle", int'(resp_valid), 0);
  endtask

  task automatic run_erase(input int lo, input int hi, input bit dn, input bit ab, input bit with_cmd);
    bit full;
    full = (lo == 0) && (hi == NS - 1);
    if (hi < lo) begin
      issue(3, 2, lo, hi, "R6 bad range");
      check("R6 no erase started", int'(erase_req), 0);
      return;
    end
    issue(3, 2, lo, hi, "R5 erase grant");
    check("R5 erase_req up", int'(erase_req), 1);
    check("R5 erase_full", int'(erase_full), int'(full));
    check("R5 erase_lo", int'(erase_lo), lo);
    check("R5 erase_hi", int'(erase_hi), hi);
    for (int i = 0; i < 2; i++) begin
      @(posedge clk); #1;
      check("R10 stalled while busy", int'(cmd_ready), 0);
    end
    @(negedge clk);
    fl_done = dn; fl_abort = ab;
    if (with_cmd) begin
      cmd_valid = 1'b1; cmd_kind = 3'd1; cmd_region = 2'd1;
    end
    #1 check("R10 stalled in ack cycle", int'(cmd_ready), 0);
    @(posedge clk); #1;
    if (dn && !ab && full) exp_prot = 1'b0;
    check(full && dn && !ab ? "R8 prot after done" : "R9 prot kept", int'(prot_active), int'(exp_prot));
    check("R8 dbg_enable follows", int'(dbg_enable), int'(!exp_prot));
    check("R5 erase_req released", int'(erase_req), 0);
    if (with_cmd) check("R10 no answer to ack-cycle cmd", int'(resp_valid), 0);
    @(negedge clk);
    fl_done = 1'b0; fl_abort = 1'b0;
    if (with_cmd) begin
      @(posedge clk); #1;
      check("R10 cmd answered after ack", int'(resp_valid), 1);
      check("R7 read RAM after clear", int'(resp_status), want(exp_prot, 1, 1, 0, 0));
      @(negedge clk); cmd_valid = 1'b0;
    end
  endtask

  task automatic do_reset(input bit boot);
    @(negedge clk);
    rst_n = 1'b0; boot_prot_en = boot; cmd_valid = 1'b0; dbg_req = 1'b0;
    fl_done = 1'b0; fl_abort = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset prot_active", int'(prot_active), 1);
    check("R1 reset cmd_ready", int'(cmd_ready), 0);
    check("R1 reset dbg_enable", int'(dbg_enable), 0);
    check("R1 reset dbg_gnt", int'(dbg_gnt), 0);
    check("R1 reset resp_valid", int'(resp_valid), 0);
    check("R1 reset erase_req", int'(erase_req), 0);
    @(negedge clk);
    rst_n = 1'b1;
    cmd_valid = 1'b1; cmd_kind = 3'd0; cmd_region = 2'd0;
    #1 check("R1 not ready before load", int'(cmd_ready), 0);
    @(posedge clk); #1;
    check("R1 early cmd stalled", int'(resp_valid), 0);
    check("R1 loaded prot", int'(prot_active), int'(boot));
    check("R1 ready after load", int'(cmd_ready), 1);
    check("R2 dbg_enable after load", int'(dbg_enable), int'(!boot));
    @(posedge clk); #1;
    check("R4 early identify answered", int'(resp_valid), 1);
    check("R4 early identify status", int'(resp_status), 1);
    @(negedge clk); cmd_valid = 1'b0;
    exp_prot = boot;
  endtask

  task automatic dbg_try(input string tag);
    @(negedge clk); dbg_req = 1'b1;
    @(posedge clk); #1;
    check({tag, " dbg_gnt"}, int'(dbg_gnt), int'(!exp_prot));
    check({tag, " dbg_enable"}, int'(dbg_enable), int'(!exp_prot));
    @(negedge clk); dbg_req = 1'b0;
    @(posedge clk); #1;
    check("R2 dbg_gnt drops", int'(dbg_gnt), 0);
  endtask

  task automatic sweep(input string tag);
    for (int k = 0; k < 8; k++) begin
      if (k == 3) continue;
      for (int r = 0; r < 4; r++) issue(k, r, 5, 2, tag);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset(1'b1);
    dbg_try("R2 protected");
    sweep("R3 R4 protected sweep");
    run_erase(9, 2, 1'b0, 1'b0, 1'b0);          // R6
    run_erase(0, 14, 1'b1, 1'b0, 1'b0);         // R9 partial
    run_erase(1, 15, 1'b1, 1'b0, 1'b0);         // R9 partial
    run_erase(0, 15, 1'b0, 1'b1, 1'b0);         // R9 abort
    run_erase(0, 15, 1'b1, 1'b1, 1'b0);         // R9 abort beats done
    check("R9 still closed", int'(prot_active), 1);
    run_erase(0, 15, 1'b1, 1'b0, 1'b1);         // R8 R10
    dbg_try("R2 open");
    sweep("R7 open sweep");
    run_erase(4, 4, 1'b1, 1'b0, 1'b0);          // R5 open
    run_erase(7, 3, 1'b0, 1'b0, 1'b0);          // R6 open
    repeat (5) @(posedge clk);
    #1 check("R11 stays clear", int'(prot_active), 0);
    do_reset(1'b0);
    dbg_try("R2 boot open");
    issue(2, 2, 0, 0, "R7 write flash boot open");
    do_reset(1'b1);
    issue(1, 2, 0, 0, "R3 read flash after re-reset");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule